// File: doc/BRIEF.md
# Spindle Motor Three-Level PWM Driver

This block turns a signed spindle-servo command into a three-level pulse-width signal for an external spindle motor driver. The command is a direction bit (speed up or slow down) and a 5-bit magnitude. The block divides the master clock down to a tick of about 236 ns, which is a 4.2336 MHz rate. Each carrier period is a fixed number of these ticks.

At the start of each period the block latches the command and the rate mode. The output is then driven for as many ticks as the magnitude asks. The drive level is high to speed the motor up and low to slow it down. For the rest of the period the output is released to high impedance.

The tri-state output is presented as a level plus an output enable for the pad. The base mode uses a 32-tick period, about 132 kHz. The fast mode uses a 16-tick period, about 264 kHz, and halves the magnitude. A one-clock strobe marks each period start, so the servo can update its command once per period.

Top module: `spm_pwm_top`

## Requirements
- R1: A tick occurs once every `TICK_DIV` master clocks; with the default of 4 a base period is 128 clocks.
- R2: With the rate-mode input low when a period starts, that period lasts 32 ticks.
- R3: With the rate-mode input high when a period starts, that period lasts 16 ticks.
- R4: In base mode the output enable is high for exactly `mag` ticks, contiguously, starting in the first clock of the period.
- R5: In fast mode the output enable is high for exactly `mag >> 1` ticks, contiguously, starting in the first clock of the period.
- R6: While the output enable is high, the drive level is 1 when `cmd_decel` is 0 (accelerate) and 0 when `cmd_decel` is 1 (decelerate), constant for the whole pulse.
- R7: Outside the active pulse the output enable is 0, meaning high impedance.
- R8: A magnitude of zero, or a magnitude of 1 in fast mode, keeps the output enable at 0 for the whole period.
- R9: The magnitude, direction and rate mode are sampled only at the period boundary; changes within a period do not affect that period.
- R10: While synchronous reset (`rst_n` low) is active, the output enable and the strobe are 0. The first period starts at the first tick after release, no later than `TICK_DIV`+2 clocks after it.
- R11: `period_start` is high for exactly one clock, the first clock of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_mag | input | 5 | Drive magnitude in ticks (0 to 31) |
| cmd_decel | input | 1 | Direction: 0 accelerate, 1 decelerate |
| fast_mode | input | 1 | 1 selects the doubled carrier rate |
| pwm_level | output | 1 | Level to drive while enabled |
| pwm_oe | output | 1 | Pad output enable; 0 means high impedance |
| period_start | output | 1 | One-clock strobe at the start of each period |

## Verification
A corrupted phase counter shows up at the ports within one period. The spacing between `period_start` strobes changes away from 128 or 64 clocks, or the pulse no longer begins on the strobe. A wrong latched width or direction changes the enable-high count or the level within the very next period. Re-sampling the command mid-period shows up in the period where the bench deliberately changes the command right after the strobe.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int SPM_MAG_W = 5;

    typedef struct packed {
        logic [SPM_MAG_W-1:0] phase;
        logic [SPM_MAG_W-1:0] width;
        logic                 decel;
        logic                 fast;
        logic                 oe;
        logic                 start;
    } spm_core_t;
endpackage

// File: rtl/spm_tick_gen.sv
module spm_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             tick_d, tick_q;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        tick_d = 1'b0;
        if (cnt_q == CNT_LAST) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    generate
        if (TICK_DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q) else $error("tick too close"); // R1
        end
    endgenerate
endmodule

// File: rtl/spm_pwm_core.sv
module spm_pwm_core
    import spm_pkg::*;
#(
    parameter int MAG_W = SPM_MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [MAG_W-1:0] cmd_mag,
    input  logic             cmd_decel,
    input  logic             fast_mode,
    output logic             pwm_level,
    output logic             pwm_oe,
    output logic             period_start
);
    localparam logic [MAG_W-1:0] LAST_BASE = {MAG_W{1'b1}};
    localparam logic [MAG_W-1:0] LAST_FAST = {1'b0, {(MAG_W-1){1'b1}}};

    spm_core_t st_d, st_q;
    logic [MAG_W-1:0] last;
    logic [MAG_W-1:0] new_width;
    logic [MAG_W-1:0] phase_inc;

    always_comb begin
        last      = st_q.fast ? LAST_FAST : LAST_BASE;
        new_width = fast_mode ? (cmd_mag >> 1) : cmd_mag;
        phase_inc = st_q.phase + 1'b1;
        st_d       = st_q;
        st_d.start = 1'b0;
        if (tick) begin
            if (st_q.phase == last) begin
                st_d.phase = '0;
                st_d.width = new_width;
                st_d.decel = cmd_decel;
                st_d.fast  = fast_mode;
                st_d.start = 1'b1;
                st_d.oe    = (new_width != '0);
            end else begin
                st_d.phase = phase_inc;
                st_d.oe    = (phase_inc < st_q.width);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= LAST_BASE;
            st_q.width <= '0;
            st_q.decel <= 1'b0;
            st_q.fast  <= 1'b0;
            st_q.oe    <= 1'b0;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_level    = ~st_q.decel;
    assign pwm_oe       = st_q.oe;
    assign period_start = st_q.start;

    AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_oe) |-> period_start) else $error("pulse began mid-period"); // R4
    AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe && $past(pwm_oe)) |-> $stable(pwm_level)) else $error("level moved in pulse"); // R6
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> ($stable(st_q.width) && $stable(st_q.decel) && $stable(st_q.fast)))
        else $error("command changed mid-period"); // R9
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start) else $error("strobe wider than one clock"); // R11
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |-> (st_q.phase <= LAST_FAST)) else $error("fast phase overran"); // R3
endmodule

// File: rtl/spm_pwm_top.sv
module spm_pwm_top
    import spm_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int MAG_W    = SPM_MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] cmd_mag,
    input  logic             cmd_decel,
    input  logic             fast_mode,
    output logic             pwm_level,
    output logic             pwm_oe,
    output logic             period_start
);
    logic tick;

    spm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    spm_pwm_core #(.MAG_W(MAG_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cmd_mag      (cmd_mag),
        .cmd_decel    (cmd_decel),
        .fast_mode    (fast_mode),
        .pwm_level    (pwm_level),
        .pwm_oe       (pwm_oe),
        .period_start (period_start)
    );
endmodule

// File: tb/tb_spm_pwm_top.sv
`timescale 1ns/1ps
module tb_spm_pwm_top;
    localparam int DIV = 4;
    localparam int NCMD = 12;

    typedef struct packed {
        logic [4:0] mag;
        logic       decel;
        logic       fast;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] cmd_mag = '0;
    logic cmd_decel = 1'b0;
    logic fast_mode = 1'b0;
    logic pwm_level, pwm_oe, period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    spm_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_mag(cmd_mag), .cmd_decel(cmd_decel),
        .fast_mode(fast_mode), .pwm_level(pwm_level), .pwm_oe(pwm_oe),
        .period_start(period_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    item_t plan [NCMD];
    initial begin
        plan[0]  = '{mag: 5'd31, decel: 1'b0, fast: 1'b0};
        plan[1]  = '{mag: 5'd1,  decel: 1'b1, fast: 1'b0};
        plan[2]  = '{mag: 5'd0,  decel: 1'b0, fast: 1'b0};
        plan[3]  = '{mag: 5'd16, decel: 1'b0, fast: 1'b0};
        plan[4]  = '{mag: 5'd31, decel: 1'b0, fast: 1'b1};
        plan[5]  = '{mag: 5'd1,  decel: 1'b1, fast: 1'b1};
        plan[6]  = '{mag: 5'd10, decel: 1'b1, fast: 1'b1};
        plan[7]  = '{mag: 5'd0,  decel: 1'b1, fast: 1'b0};
        plan[8]  = '{mag: 5'd7,  decel: 1'b1, fast: 1'b0};
        plan[9]  = '{mag: 5'd2,  decel: 1'b0, fast: 1'b1};
        plan[10] = '{mag: 5'd30, decel: 1'b1, fast: 1'b0};
        plan[11] = '{mag: 5'd0,  decel: 1'b0, fast: 1'b1};
    end

    // Driver: applies one command per period, with a decoy change right after each strobe
    initial begin
        int wait_cyc;
        cmd_mag = plan[0].mag; cmd_decel = plan[0].decel; fast_mode = plan[0].fast;
        sb_q.push_back(plan[0]);
        repeat (5) begin
            @(negedge clk);
            check(pwm_oe == 1'b0, "R10 reset oe", pwm_oe, 0);
            check(period_start == 1'b0, "R10 reset strobe", period_start, 0);
        end
        rst_n = 1'b1;
        wait_cyc = 0;
        do begin
            @(negedge clk);
            wait_cyc++;
        end while (!period_start && wait_cyc < 50);
        check(wait_cyc <= DIV + 2, "R10 first period", wait_cyc, DIV + 2);
        for (int i = 1; i < NCMD; i++) begin
            if (i > 1) begin
                @(negedge clk);
                while (!period_start) @(negedge clk);
            end
            cmd_mag = ~plan[i].mag; cmd_decel = ~plan[i].decel; fast_mode = ~plan[i].fast; // R9 decoy
            repeat (3) @(negedge clk);
            cmd_mag = plan[i].mag; cmd_decel = plan[i].decel; fast_mode = plan[i].fast;
            sb_q.push_back(plan[i]);
        end
        repeat (3) begin
            @(negedge clk);
            while (!period_start) @(negedge clk);
        end
        done = 1'b1;
    end

    // Monitor: measures each period and compares with the popped expectation
    initial begin
        item_t cur;
        bit have = 1'b0;
        int cyc = 0, on_cnt = 0, rises = 0;
        bit lvl_bad = 1'b0, first_on = 1'b0, prev_oe = 1'b0;
        int exp_w, exp_len;
        @(posedge rst_n);
        while (!done) begin
            @(negedge clk);
            if (period_start) begin
                if (have) begin
                    exp_w   = cur.fast ? int'(cur.mag >> 1) : int'(cur.mag);
                    exp_len = (cur.fast ? 16 : 32) * DIV;
                    check(cyc == exp_len, cur.fast ? "R3 period length" : "R2 R1 period length", cyc, exp_len);
                    check(on_cnt == exp_w * DIV, cur.fast ? "R5 active width" : "R4 active width", on_cnt, exp_w * DIV);
                    if (exp_w == 0)
                        check(on_cnt == 0, "R8 zero magnitude", on_cnt, 0);
                    else
                        check(first_on && rises == 0, "R4 R7 pulse contiguous from start", rises, 0);
                    check(!lvl_bad, "R6 drive level", lvl_bad, 0);
                end
                if (sb_q.size() == 0) begin
                    have = 1'b0;
                end else begin
                    cur = sb_q.pop_front();
                    have = 1'b1;
                end
                cyc = 0; on_cnt = 0; rises = 0; lvl_bad = 1'b0;
                first_on = pwm_oe;
                prev_oe = pwm_oe;
            end else begin
                if (pwm_oe && !prev_oe) rises++;
                prev_oe = pwm_oe;
            end
            cyc++;
            if (cyc == 2)
                check(!period_start, "R11 strobe width", period_start, 0);
            if (pwm_oe) begin
                on_cnt++;
                if (have && pwm_level != !cur.decel) lvl_bad = 1'b1;
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule